// File: doc/BRIEF.md
# Monitor Channel Byte Handshake Controller

This block moves bytes across the monitor slot of a framed 8 kHz time-division bus. Each frame carries one monitor byte and two active-low handshake bits. The sender drives one bit to announce a byte. The receiver drives the other bit to acknowledge it. All bus-side state changes happen on the clock edge that samples the one-cycle `frame_i` strobe, which marks the slot as valid. The block holds one transmitter and one receiver, so a single instance can both send and receive.

On the transmit side, a host writes the first byte, raises the continue level and waits for an acknowledge pulse. After each pulse it writes the next byte. It drops the continue level to close the message. The busy output must be low before a new message is started. When enabled, a frame-counting watchdog aborts a transfer that waits too long for an acknowledge. On the receive side, a byte is accepted once it has been seen unchanged in two frames with the announce bit active. Only messages whose first byte has the device address in its upper nibble are accepted. The receiver also reports end of message and protocol errors.

Top module: `mon_handshake`

## Requirements
- R1: After reset, `mx_tx_o` and `mr_tx_o` are 1 (inactive) and `active_o` is 0. The bus-side outputs change only on a clock edge where `frame_i` is 1.
- R2: Once a byte has been loaded with `tx_load_i`, `active_o` is 1. If `tx_cont_i` is 1 and the transmitter is idle, the next frame drives `mx_tx_o` to 0 and places the byte on `mon_tx_o`.
- R3: While a byte is being sent, a frame where `mr_rx_i` is 0 after being 1 in the previous frame raises `ack_irq_o` for one cycle. The byte and `mx_tx_o` = 0 are then held until the host writes a new byte or ends the message.
- R4: If a new byte is loaded after an acknowledge and `tx_cont_i` is 1, the transmitter drives `mx_tx_o` = 1 for exactly one frame. It then drives `mx_tx_o` = 0 with the new byte.
- R5: If `tx_cont_i` is 0 after an acknowledge, the next frame drives `mx_tx_o` to 1. `active_o` falls after two further consecutive frames in which `mr_rx_i` is 1.
- R6: With `tout_en_i` = 1, a byte left unacknowledged for `TOUT_FRAMES` frames causes a one-cycle `abort_irq_o`, `mx_tx_o` = 1 and `active_o` = 0. With `tout_en_i` = 0, the transmitter waits indefinitely.
- R7: A byte seen on `mon_rx_i` in two consecutive frames with `mx_rx_i` = 0 is delivered on `rx_data_o` with a one-cycle `rx_valid_o`, and `mr_tx_o` goes to 0. If the byte is held unchanged after that, it is not delivered again.
- R8: A frame with `mx_rx_i` = 1 makes `mr_tx_o` 1.
- R9: If the first byte of a message does not have `ADDR_CODE` (default 4'b1010) in bits 7:4, it is neither acknowledged nor delivered. The rest of that message is ignored.
- R10: After an acknowledge, if `mx_rx_i` stays 0 while the byte changes, `err_irq_o` pulses and `mr_tx_o` goes to 1. The rest of that message is ignored.
- R11: Two consecutive frames with `mx_rx_i` = 1 and `mr_tx_o` = 1 end a message, and `end_irq_o` pulses if the message was accepted. A single inactive frame does not end a message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_i | input | 1 | One-cycle strobe: monitor slot valid this frame |
| mon_rx_i | input | 8 | Monitor byte received from the bus |
| mx_rx_i | input | 1 | Peer's announce bit, active low |
| mr_rx_i | input | 1 | Peer's acknowledge bit, active low |
| tx_data_i | input | 8 | Host byte to send |
| tx_load_i | input | 1 | Host write strobe for `tx_data_i` |
| tx_cont_i | input | 1 | Host continue level; 0 closes the message |
| tout_en_i | input | 1 | Enables the lock-up watchdog |
| mon_tx_o | output | 8 | Monitor byte driven onto the bus |
| mx_tx_o | output | 1 | Own announce bit, active low |
| mr_tx_o | output | 1 | Own acknowledge bit, active low |
| active_o | output | 1 | Transmitter busy |
| ack_irq_o | output | 1 | Byte acknowledged pulse |
| abort_irq_o | output | 1 | Transmit aborted by watchdog pulse |
| rx_data_o | output | 8 | Last accepted byte |
| rx_valid_o | output | 1 | Byte accepted pulse |
| end_irq_o | output | 1 | Message ended pulse |
| err_irq_o | output | 1 | Receive protocol error pulse |

## Verification
The embedded properties check several rules on every cycle:
- An inactive announce bit always releases the acknowledge bit on the next frame.
- A delivered byte always comes with an active acknowledge, and an error or end always with a released one.
- The handshake bits never move between frame strobes.
- An idle transmitter never announces.
- The watchdog count stays in range.

Other behaviour depends on multi-frame histories that only the bench scenarios can show. These are:
- the falling-edge acknowledge rule;
- the one-frame gap between bytes;
- the two-frame closing rule;
- the exact frame on which the watchdog fires;
- the address filter;
- the suppression of the rest of a message after an error.

// File: rtl/mon_pkg.sv
package mon_pkg;
  typedef enum logic [2:0] {
    TX_IDLE,
    TX_SEND,
    TX_ACKD,
    TX_GAP,
    TX_END
  } tx_state_e;
endpackage

// File: rtl/mon_timeout.sv
module mon_timeout #(
  parameter int LIMIT = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic frame_i,
  input  logic en_i,
  input  logic wait_i,
  output logic expire_o
);
  localparam int CW = (LIMIT > 2) ? $clog2(LIMIT) : 1;

  logic [CW-1:0] cnt_q;

  assign expire_o = frame_i && en_i && wait_i && (cnt_q == CW'(LIMIT - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (frame_i) cnt_q <= (en_i && wait_i && !expire_o) ? cnt_q + 1'b1 : '0;
  end

  a_r6_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(LIMIT - 1));
endmodule

// File: rtl/mon_tx.sv
module mon_tx
  import mon_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              load_i,
  input  logic              cont_i,
  input  logic              mr_i,
  input  logic              expire_i,
  output logic              wait_o,
  output logic [DATA_W-1:0] byte_o,
  output logic              mx_o,
  output logic              active_o,
  output logic              ack_o,
  output logic              abort_o
);
  tx_state_e         state_q;
  logic [DATA_W-1:0] data_q, out_q;
  logic              pend_q, mx_q, mr_prev_q, end_cnt_q, ack_q, abort_q;
  logic              mr_fall;

  assign mr_fall  = !mr_i && mr_prev_q;
  assign wait_o   = (state_q == TX_SEND);
  assign byte_o   = out_q;
  assign mx_o     = mx_q;
  assign active_o = pend_q || (state_q != TX_IDLE);
  assign ack_o    = ack_q;
  assign abort_o  = abort_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= TX_IDLE;
      data_q    <= '0;
      out_q     <= '1;
      pend_q    <= 1'b0;
      mx_q      <= 1'b1;
      mr_prev_q <= 1'b1;
      end_cnt_q <= 1'b0;
      ack_q     <= 1'b0;
      abort_q   <= 1'b0;
    end else begin
      ack_q   <= 1'b0;
      abort_q <= 1'b0;
      if (frame_i) begin
        mr_prev_q <= mr_i;
        unique case (state_q)
          TX_IDLE: if (pend_q && cont_i) begin
            state_q <= TX_SEND;
            out_q   <= data_q;
            mx_q    <= 1'b0;
            pend_q  <= 1'b0;
          end
          TX_SEND: if (mr_fall) begin
            ack_q   <= 1'b1;
            state_q <= TX_ACKD;
          end else if (expire_i) begin
            abort_q <= 1'b1;
            state_q <= TX_IDLE;
            mx_q    <= 1'b1;
            out_q   <= '1;
            pend_q  <= 1'b0;
          end
          TX_ACKD: if (!cont_i) begin
            state_q   <= TX_END;
            mx_q      <= 1'b1;
            out_q     <= '1;
            end_cnt_q <= 1'b0;
          end else if (pend_q) begin
            state_q <= TX_GAP;
            mx_q    <= 1'b1;
            out_q   <= '1;
          end
          TX_GAP: begin
            state_q <= TX_SEND;
            out_q   <= data_q;
            mx_q    <= 1'b0;
            pend_q  <= 1'b0;
          end
          TX_END: begin
            if (mr_i) begin
              if (end_cnt_q) state_q <= TX_IDLE;
              end_cnt_q <= 1'b1;
            end else begin
              end_cnt_q <= 1'b0;
            end
          end
          default: state_q <= TX_IDLE;
        endcase
      end
      if (load_i) begin
        data_q <= data_i;
        pend_q <= 1'b1;
      end
    end
  end

  a_r5_idle_no_announce: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_o |-> mx_o);
  a_r2_send_announces: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wait_o |-> !mx_o);
  a_r3_ack_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o);
  a_r6_abort_releases: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> mx_o);
  a_r1_mx_frame_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_i |=> $stable(mx_o));
endmodule

// File: rtl/mon_rx.sv
module mon_rx #(
  parameter int          DATA_W    = 8,
  parameter logic [3:0]  ADDR_CODE = 4'b1010
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_i,
  input  logic [DATA_W-1:0] byte_i,
  input  logic              mx_i,
  output logic              mr_o,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o,
  output logic              end_o,
  output logic              err_o
);
  logic [DATA_W-1:0] prev_byte_q, data_q;
  logic              prev_mx_q, mr_q, msg_q, ign_q, valid_q, end_q, err_q;
  logic              stable_new, changed_held, addr_ok;

  assign stable_new   = !mx_i && !prev_mx_q && (byte_i == prev_byte_q) && mr_q && !ign_q;
  assign changed_held = !mx_i && !prev_mx_q && (byte_i != prev_byte_q) && !mr_q;
  assign addr_ok      = (byte_i[DATA_W-1 -: 4] == ADDR_CODE);

  assign mr_o    = mr_q;
  assign data_o  = data_q;
  assign valid_o = valid_q;
  assign end_o   = end_q;
  assign err_o   = err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_byte_q <= '1;
      prev_mx_q   <= 1'b1;
      data_q      <= '0;
      mr_q        <= 1'b1;
      msg_q       <= 1'b0;
      ign_q       <= 1'b0;
      valid_q     <= 1'b0;
      end_q       <= 1'b0;
      err_q       <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      end_q   <= 1'b0;
      err_q   <= 1'b0;
      if (frame_i) begin
        prev_byte_q <= byte_i;
        prev_mx_q   <= mx_i;
        if (!mx_i) begin
          if (stable_new) begin
            msg_q <= 1'b1;
            if (msg_q || addr_ok) begin
              mr_q    <= 1'b0;
              data_q  <= byte_i;
              valid_q <= 1'b1;
            end else begin
              ign_q <= 1'b1;
            end
          end else if (changed_held) begin
            err_q <= 1'b1;
            mr_q  <= 1'b1;
            ign_q <= 1'b1;
          end
        end else begin
          mr_q <= 1'b1;
          if (prev_mx_q && mr_q && msg_q) begin
            msg_q <= 1'b0;
            ign_q <= 1'b0;
            end_q <= !ign_q;
          end
        end
      end
    end
  end

  a_r8_mr_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_i && mx_i) |=> mr_o);
  a_r7_valid_acks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> !mr_o);
  a_r10_err_releases: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> mr_o);
  a_r11_end_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    end_o |-> (mr_o && !valid_o));
  a_r1_mr_frame_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_i |=> $stable(mr_o));
endmodule

// File: rtl/mon_handshake.sv
module mon_handshake #(
  parameter int         DATA_W      = 8,
  parameter int         TOUT_FRAMES = 32,
  parameter logic [3:0] ADDR_CODE   = 4'b1010
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_i,
  input  logic [DATA_W-1:0] mon_rx_i,
  input  logic              mx_rx_i,
  input  logic              mr_rx_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              tx_load_i,
  input  logic              tx_cont_i,
  input  logic              tout_en_i,
  output logic [DATA_W-1:0] mon_tx_o,
  output logic              mx_tx_o,
  output logic              mr_tx_o,
  output logic              active_o,
  output logic              ack_irq_o,
  output logic              abort_irq_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  output logic              end_irq_o,
  output logic              err_irq_o
);
  logic tx_wait, tx_expire;

  mon_timeout #(.LIMIT(TOUT_FRAMES)) u_tout (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .frame_i  (frame_i),
    .en_i     (tout_en_i),
    .wait_i   (tx_wait),
    .expire_o (tx_expire)
  );

  mon_tx #(.DATA_W(DATA_W)) u_tx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .frame_i  (frame_i),
    .data_i   (tx_data_i),
    .load_i   (tx_load_i),
    .cont_i   (tx_cont_i),
    .mr_i     (mr_rx_i),
    .expire_i (tx_expire),
    .wait_o   (tx_wait),
    .byte_o   (mon_tx_o),
    .mx_o     (mx_tx_o),
    .active_o (active_o),
    .ack_o    (ack_irq_o),
    .abort_o  (abort_irq_o)
  );

  mon_rx #(.DATA_W(DATA_W), .ADDR_CODE(ADDR_CODE)) u_rx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .frame_i (frame_i),
    .byte_i  (mon_rx_i),
    .mx_i    (mx_rx_i),
    .mr_o    (mr_tx_o),
    .data_o  (rx_data_o),
    .valid_o (rx_valid_o),
    .end_o   (end_irq_o),
    .err_o   (err_irq_o)
  );
endmodule

// File: tb/mon_handshake_test.sv
`timescale 1ns/1ps
module mon_handshake_test;
  localparam int LIM = 6;

  logic       clk_i = 1'b0, rst_ni = 1'b0, frame_i = 1'b0;
  logic [7:0] mon_rx_i = 8'hFF, tx_data_i = 8'h00;
  logic       mx_rx_i = 1'b1, mr_rx_i = 1'b1, tx_load_i = 1'b0, tx_cont_i = 1'b0, tout_en_i = 1'b0;
  logic [7:0] mon_tx_o, rx_data_o;
  logic       mx_tx_o, mr_tx_o, active_o, ack_irq_o, abort_irq_o, rx_valid_o, end_irq_o, err_irq_o;
  logic       s_ack, s_abort, s_end, s_err;
  int         checks = 0, errors = 0;
  logic [7:0] exp_q[$];

  always #2.5 clk_i = ~clk_i;

  mon_handshake #(.TOUT_FRAMES(LIM)) uut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor: every delivered byte must match the next expected one
  always @(negedge clk_i) if (rst_ni && rx_valid_o) begin
    if (exp_q.size() == 0) chk(1'b0, "R7 unexpected delivery", rx_data_o, 0);
    else begin
      logic [7:0] e;
      e = exp_q.pop_front();
      chk(rx_data_o == e, "R7 delivered byte", rx_data_o, e);
    end
  end

  task automatic tick(input logic mx, input logic [7:0] b, input logic mr);
    mx_rx_i = mx; mon_rx_i = b; mr_rx_i = mr; frame_i = 1'b1;
    @(negedge clk_i);
    frame_i = 1'b0;
    s_ack = ack_irq_o; s_abort = abort_irq_o; s_end = end_irq_o; s_err = err_irq_o;
    @(negedge clk_i);
  endtask

  task automatic host_load(input logic [7:0] d);
    tx_data_i = d; tx_load_i = 1'b1;
    @(negedge clk_i);
    tx_load_i = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk(mx_tx_o && mr_tx_o && !active_o, "R1 reset state", {mx_tx_o, mr_tx_o, active_o}, 3'b110);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // receive: accepted message, two bytes
    tick(1'b0, 8'hA3, 1'b1);
    chk(mr_tx_o == 1'b1, "R7 no ack after one frame", mr_tx_o, 1);
    exp_q.push_back(8'hA3);
    tick(1'b0, 8'hA3, 1'b1);
    chk(mr_tx_o == 1'b0, "R7 ack after two equal frames", mr_tx_o, 0);
    tick(1'b0, 8'hA3, 1'b1);
    chk(mr_tx_o == 1'b0, "R7 held byte keeps ack", mr_tx_o, 0);
    tick(1'b1, 8'hFF, 1'b1);
    chk(mr_tx_o == 1'b1, "R8 release on inactive MX", mr_tx_o, 1);
    chk(s_end == 1'b0, "R11 one inactive frame is no end", s_end, 0);
    tick(1'b0, 8'h5C, 1'b1);
    exp_q.push_back(8'h5C);
    tick(1'b0, 8'h5C, 1'b1);
    chk(mr_tx_o == 1'b0, "R7 second byte acked", mr_tx_o, 0);
    tick(1'b1, 8'hFF, 1'b1);
    chk(s_end == 1'b0, "R11 first idle frame", s_end, 0);
    tick(1'b1, 8'hFF, 1'b1);
    chk(s_end == 1'b1, "R11 end after two idle frames", s_end, 1);

    // receive: wrong address code in first byte
    repeat (3) tick(1'b0, 8'h53, 1'b1);
    chk(mr_tx_o == 1'b1, "R9 foreign address not acked", mr_tx_o, 1);
    tick(1'b1, 8'hFF, 1'b1);
    repeat (2) tick(1'b0, 8'hA1, 1'b1);
    chk(mr_tx_o == 1'b1, "R9 rest of message ignored", mr_tx_o, 1);
    tick(1'b1, 8'hFF, 1'b1);
    tick(1'b1, 8'hFF, 1'b1);
    chk(s_end == 1'b0, "R9 no end for ignored message", s_end, 0);

    // receive: byte changes while still acknowledged
    tick(1'b0, 8'hA7, 1'b1);
    exp_q.push_back(8'hA7);
    tick(1'b0, 8'hA7, 1'b1);
    chk(mr_tx_o == 1'b0, "R10 recovery accepts new message", mr_tx_o, 0);
    tick(1'b0, 8'h11, 1'b1);
    chk(s_err == 1'b1, "R10 error pulse", s_err, 1);
    chk(mr_tx_o == 1'b1, "R10 ack released", mr_tx_o, 1);
    tick(1'b0, 8'h11, 1'b1);
    chk(mr_tx_o == 1'b1, "R10 rest ignored", mr_tx_o, 1);
    tick(1'b1, 8'hFF, 1'b1);
    tick(1'b1, 8'hFF, 1'b1);
    chk(s_end == 1'b0, "R11 no end after error", s_end, 0);

    // transmit: two-byte message
    tx_cont_i = 1'b1;
    host_load(8'hA5);
    chk(active_o == 1'b1, "R2 busy after load", active_o, 1);
    tick(1'b1, 8'hFF, 1'b1);
    chk(mx_tx_o == 1'b0 && mon_tx_o == 8'hA5, "R2 first byte announced", {mx_tx_o, mon_tx_o}, 9'h0A5);
    tick(1'b1, 8'hFF, 1'b1);
    chk(s_ack == 1'b0, "R3 no ack without MR fall", s_ack, 0);
    tick(1'b1, 8'hFF, 1'b0);
    chk(s_ack == 1'b1, "R3 ack on MR fall", s_ack, 1);
    tick(1'b1, 8'hFF, 1'b0);
    chk(s_ack == 1'b0 && mx_tx_o == 1'b0 && mon_tx_o == 8'hA5, "R3 byte held after ack",
        {s_ack, mx_tx_o, mon_tx_o}, 10'h0A5);
    host_load(8'h3C);
    tick(1'b1, 8'hFF, 1'b0);
    chk(mx_tx_o == 1'b1, "R4 one-frame gap", mx_tx_o, 1);
    tick(1'b1, 8'hFF, 1'b1);
    chk(mx_tx_o == 1'b0 && mon_tx_o == 8'h3C, "R4 next byte announced", {mx_tx_o, mon_tx_o}, 9'h03C);
    tick(1'b1, 8'hFF, 1'b0);
    chk(s_ack == 1'b1, "R3 second ack", s_ack, 1);
    tx_cont_i = 1'b0;
    tick(1'b1, 8'hFF, 1'b1);
    chk(mx_tx_o == 1'b1 && active_o == 1'b1, "R5 closing starts", {mx_tx_o, active_o}, 2'b11);
    tick(1'b1, 8'hFF, 1'b1);
    chk(active_o == 1'b1, "R5 still busy after one idle frame", active_o, 1);
    tick(1'b1, 8'hFF, 1'b1);
    chk(active_o == 1'b0, "R5 done after two idle frames", active_o, 0);

    // transmit: watchdog off, then on
    tx_cont_i = 1'b1;
    host_load(8'h99);
    tick(1'b1, 8'hFF, 1'b1);
    chk(mx_tx_o == 1'b0, "R2 third message announced", mx_tx_o, 0);
    begin
      bit any_abort = 1'b0;
      for (int i = 0; i < LIM + 2; i++) begin
        tick(1'b1, 8'hFF, 1'b1);
        any_abort |= s_abort;
      end
      chk(!any_abort && mx_tx_o == 1'b0, "R6 disabled watchdog waits", {any_abort, mx_tx_o}, 0);
    end
    tout_en_i = 1'b1;
    begin
      bit any_abort = 1'b0;
      for (int i = 0; i < LIM - 1; i++) begin
        tick(1'b1, 8'hFF, 1'b1);
        any_abort |= s_abort;
      end
      chk(!any_abort, "R6 no abort before limit", any_abort, 0);
    end
    tick(1'b1, 8'hFF, 1'b1);
    chk(s_abort == 1'b1 && mx_tx_o == 1'b1 && active_o == 1'b0, "R6 abort at limit",
        {s_abort, mx_tx_o, active_o}, 3'b110);

    chk(exp_q.size() == 0, "R7 all bytes delivered", exp_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule